// File: doc/BRIEF.md
# TLB Replacement Pointer and Translation Control Register

This block holds the control state for a memory-management unit with a 64-entry unified TLB. It keeps three flag bits: one that turns address translation on, one that picks single or multiple virtual space mode, and one that limits store-queue access to privileged code. It also holds a write-one command that clears every valid bit in the TLBs. Next to these flags it keeps a 6-bit replacement pointer and a 6-bit wrap boundary. The pointer names the TLB entry that the next load-TLB operation overwrites.

Each TLB lookup, signalled by a strobe, moves the pointer on by one. If the boundary is nonzero, the pointer returns to 0 after it reaches the boundary. Software can write the pointer to a value above the boundary. In that case the pointer counts on up to 63 and then wraps to 0. A load-TLB operation reads the pointer and does not move it. The block also registers a store-queue fault when user code reaches a store queue that is reserved for privileged code.

Software writes the whole register in one cycle. The read value always shows the current register contents.

Top module: `mmu_ctl_reg`

## Requirements
- R1: After synchronous reset, the pointer, the boundary and all flags are 0, and `inval_pulse`, `sq_fault` and `rd_data` are all 0.
- R2: A cycle with `wr_en` high loads the fields from `wr_data` as follows: bit 0 is translation enable, bit 2 is single-space mode, bit 3 is store-queue privileged-only, bits 13:8 are the boundary and bits 21:16 are the pointer. `rd_data` returns these fields at the same positions, and every other bit reads as 0.
- R3: On each clock edge where `tlb_access` is high and `tlb_load` and `wr_en` are low, and the wrap condition of R4 does not hold, `repl_idx` increases by one.
- R4: If the boundary is nonzero and the pointer equals the boundary, the next advance sets the pointer to 0.
- R5: If the boundary is 0, the pointer counts modulo 64, so 63 is followed by 0.
- R6: If the pointer is above a nonzero boundary, it keeps counting up through 63 and then wraps to 0.
- R7: A cycle with `tlb_load` high never advances the pointer, even when `tlb_access` is also high.
- R8: If a write and an access fall in the same cycle, the written pointer value is loaded and the increment is dropped.
- R9: Writing 1 to bit 1 of `wr_data` drives `inval_pulse` high for exactly the one cycle after the write edge. Bit 1 of `rd_data` always reads 0.
- R10: If `sq_access` and `user_mode` are high while the store-queue bit and the translation-enable bit are both 1, `sq_fault` is high in the following cycle. If the store-queue bit is 0, `sq_fault` stays low.
- R11: While translation enable is 0, `sq_fault` is never raised.
- R12: `xlat_en` and `single_space` follow the stored flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register value |
| tlb_access | input | 1 | Unified TLB access strobe, one per access cycle |
| tlb_load | input | 1 | Load-TLB strobe; uses `repl_idx` and does not advance it |
| sq_access | input | 1 | Store-queue access in this cycle |
| user_mode | input | 1 | The current access runs at user privilege |
| repl_idx | output | 6 | Entry index for the next replacement |
| inval_pulse | output | 1 | One-cycle pulse that clears all TLB valid bits |
| xlat_en | output | 1 | Address translation enabled |
| single_space | output | 1 | 1 selects single virtual space mode, 0 selects multiple |
| sq_fault | output | 1 | Registered store-queue user-access fault |

## Verification
The assertions assume that the strobes are clean and synchronous, and that inputs are driven low while reset is held. They also assume that a write and a load may arrive together, and they resolve that case in favour of the write. The random stimulus keeps writes rare so that long runs of accesses can reach the boundary. It draws boundary and pointer values over the full 6-bit range, so pointers above the boundary occur often. It holds every input at 0 during reset. Directed sequences set the pointer just below a small boundary, above the boundary, and at 62 with a zero boundary, so that each wrap rule is exercised deliberately.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
  localparam int IDX_W   = 6;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 0;
  localparam int INV_BIT = 1;
  localparam int SV_BIT  = 2;
  localparam int SQ_BIT  = 3;
  localparam int BND_LSB = 8;
  localparam int CNT_LSB = 16;

  typedef struct packed {
    logic xlat_en;
    logic single_space;
    logic sq_priv;
  } mmu_flags_t;
endpackage

// File: rtl/mmu_repl_counter.sv
module mmu_repl_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic [W-1:0] set_val,
  input  logic         step,
  input  logic [W-1:0] bnd,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         at_bnd;
  logic [W-1:0] nxt;

  always_comb begin
    at_bnd = (bnd != '0) && (cnt == bnd);
    nxt    = at_bnd ? '0 : cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (set_en) cnt <= set_val;
    else if (step)   cnt <= nxt;
  end
endmodule

// File: rtl/mmu_ctl_fields.sv
module mmu_ctl_fields
  import mmu_ctl_pkg::*;
#(
  parameter int IW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output mmu_flags_t    flags,
  output logic [IW-1:0] bnd,
  output logic          inval_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags       <= '0;
      bnd         <= '0;
      inval_pulse <= 1'b0;
    end else begin
      inval_pulse <= wr_en && wr_data[INV_BIT];
      if (wr_en) begin
        flags.xlat_en      <= wr_data[EN_BIT];
        flags.single_space <= wr_data[SV_BIT];
        flags.sq_priv      <= wr_data[SQ_BIT];
        bnd                <= wr_data[BND_LSB +: IW];
      end
    end
  end
endmodule

// File: rtl/mmu_sq_guard.sv
module mmu_sq_guard
  import mmu_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sq_access,
  input  logic       user_mode,
  input  mmu_flags_t flags,
  output logic       sq_fault
);
  always_ff @(posedge clk) begin
    if (rst) sq_fault <= 1'b0;
    else     sq_fault <= sq_access && user_mode && flags.sq_priv && flags.xlat_en;
  end
endmodule

// File: rtl/mmu_ctl_reg.sv
module mmu_ctl_reg
  import mmu_ctl_pkg::*;
#(
  parameter int IDX_W  = mmu_ctl_pkg::IDX_W,
  parameter int DATA_W = mmu_ctl_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tlb_access,
  input  logic              tlb_load,
  input  logic              sq_access,
  input  logic              user_mode,
  output logic [IDX_W-1:0]  repl_idx,
  output logic              inval_pulse,
  output logic              xlat_en,
  output logic              single_space,
  output logic              sq_fault
);
  mmu_flags_t       flags;
  logic [IDX_W-1:0] bnd;

  mmu_ctl_fields #(.IW(IDX_W), .DW(DATA_W)) u_fields (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .flags(flags), .bnd(bnd), .inval_pulse(inval_pulse)
  );

  mmu_repl_counter #(.W(IDX_W)) u_cnt (
    .clk(clk), .rst(rst),
    .set_en(wr_en), .set_val(wr_data[CNT_LSB +: IDX_W]),
    .step(tlb_access && !tlb_load), .bnd(bnd), .cnt(repl_idx)
  );

  mmu_sq_guard u_sq (
    .clk(clk), .rst(rst), .sq_access(sq_access), .user_mode(user_mode),
    .flags(flags), .sq_fault(sq_fault)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[EN_BIT]              = flags.xlat_en;
    rd_data[SV_BIT]              = flags.single_space;
    rd_data[SQ_BIT]              = flags.sq_priv;
    rd_data[BND_LSB +: IDX_W]    = bnd;
    rd_data[CNT_LSB +: IDX_W]    = repl_idx;
    xlat_en                      = flags.xlat_en;
    single_space                 = flags.single_space;
  end
endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk
  import mmu_ctl_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              tlb_access,
  input logic              tlb_load,
  input logic              sq_access,
  input logic              user_mode,
  input logic [IDX_W-1:0]  repl_idx,
  input logic              inval_pulse,
  input logic              xlat_en,
  input logic              sq_fault
);
  logic [IDX_W-1:0] bnd_q;
  logic             adv;
  assign bnd_q = rd_data[BND_LSB +: IDX_W];
  assign adv   = tlb_access && !tlb_load && !wr_en;

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !(bnd_q != '0 && repl_idx == bnd_q)) |=> repl_idx == IDX_W'($past(repl_idx) + 1'b1));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && bnd_q != '0 && repl_idx == bnd_q) |=> repl_idx == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (tlb_load && !wr_en) |=> $stable(repl_idx));

  assert_wr_wins_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> repl_idx == $past(wr_data[CNT_LSB +: IDX_W]));

  assert_pulse_src_R9: assert property (@(posedge clk) disable iff (rst)
    inval_pulse |-> $past(wr_en && wr_data[INV_BIT]));

  assert_inv_reads0_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_data[INV_BIT]);

  assert_no_fault_off_R11: assert property (@(posedge clk) disable iff (rst)
    sq_fault |-> $past(xlat_en && sq_access && user_mode));
endmodule

bind mmu_ctl_reg mmu_ctl_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .tlb_access(tlb_access), .tlb_load(tlb_load), .sq_access(sq_access),
  .user_mode(user_mode), .repl_idx(repl_idx), .inval_pulse(inval_pulse),
  .xlat_en(xlat_en), .sq_fault(sq_fault)
);

// File: tb/mmu_ctl_reg_tb.sv
`timescale 1ns/1ps
module mmu_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tlb_access = 1'b0, tlb_load = 1'b0, sq_access = 1'b0, user_mode = 1'b0;
  logic [5:0]  repl_idx;
  logic        inval_pulse, xlat_en, single_space, sq_fault;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [5:0] m_cnt = '0, m_bnd = '0;
  logic       m_en = 0, m_sv = 0, m_sq = 0, m_inv = 0, m_fault = 0;

  always #2.5 clk = ~clk;

  mmu_ctl_reg u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tlb_access(tlb_access), .tlb_load(tlb_load), .sq_access(sq_access),
    .user_mode(user_mode), .repl_idx(repl_idx), .inval_pulse(inval_pulse),
    .xlat_en(xlat_en), .single_space(single_space), .sq_fault(sq_fault)
  );

  function automatic logic [5:0] next_cnt(input logic [5:0] c, input logic [5:0] b);
    if (b != 6'd0 && c == b) return 6'd0;
    return c + 6'd1;
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[0] = m_en; r[2] = m_sv; r[3] = m_sq;
    r[13:8] = m_bnd; r[21:16] = m_cnt;
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] c, input logic [5:0] b,
                                     input logic en, input logic inv,
                                     input logic sv, input logic sq);
    return {10'd0, c, 2'd0, b, 4'd0, sq, sv, inv, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, 32'(repl_idx), 32'(m_cnt));
    chk("R2", rd_data, exp_rd());
    chk("R12", {30'd0, xlat_en, single_space}, {30'd0, m_en, m_sv});
    chk("R9", 32'(inval_pulse), 32'(m_inv));
    chk("R10", 32'(sq_fault), 32'(m_fault));
  endtask

  // called at a negedge; drives, lets one edge pass, checks at the next negedge
  task automatic step(input logic we, input logic [31:0] wd, input logic acc,
                      input logic ld, input logic sqa, input logic um, input string tag);
    wr_en = we; wr_data = wd; tlb_access = acc; tlb_load = ld;
    sq_access = sqa; user_mode = um;
    @(posedge clk);
    m_inv   = we && wd[1];
    m_fault = sqa && um && m_sq && m_en;
    if (we) begin
      m_cnt = wd[21:16]; m_bnd = wd[13:8];
      m_en = wd[0]; m_sv = wd[2]; m_sq = wd[3];
    end else if (acc && !ld) begin
      m_cnt = next_cnt(m_cnt, m_bnd);
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state, before any edge with reset low
    chk("R1", {rd_data[31:0]}, 32'd0);
    chk("R1", {26'd0, repl_idx}, 32'd0);
    chk("R1", {29'd0, inval_pulse, sq_fault, xlat_en}, 32'd0);

    // R4: boundary 5, start at 3 -> 4,5,0
    step(1, mk(6'd3, 6'd5, 1, 0, 0, 0), 0, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 0, "R4");
    chk("R4", 32'(repl_idx), 32'd0);
    // R6: above boundary -> 61,62,63,0
    step(1, mk(6'd60, 6'd5, 1, 0, 1, 0), 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, "R6");
    chk("R6", 32'(repl_idx), 32'd63);
    step(0, 0, 1, 0, 0, 0, "R6");
    chk("R6", 32'(repl_idx), 32'd0);
    // R5: boundary 0 modulo 64
    step(1, mk(6'd62, 6'd0, 0, 0, 0, 0), 0, 0, 0, 0, "R2");
    step(0, 0, 1, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 0, "R5");
    chk("R5", 32'(repl_idx), 32'd0);
    // R7: load with access does not advance
    step(0, 0, 1, 1, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 0, "R7");
    chk("R7", 32'(repl_idx), 32'd0);
    // R8: write wins over access
    step(1, mk(6'd20, 6'd30, 1, 0, 0, 1), 1, 0, 0, 0, "R8");
    chk("R8", 32'(repl_idx), 32'd20);
    // R9: invalidate pulse then clear
    step(1, mk(6'd20, 6'd30, 1, 1, 0, 1), 0, 0, 0, 0, "R9");
    chk("R9", 32'(inval_pulse), 32'd1);
    chk("R9", 32'(rd_data[1]), 32'd0);
    step(0, 0, 0, 0, 0, 0, "R9");
    chk("R9", 32'(inval_pulse), 32'd0);
    // R10: sq fault from user with sq bit set
    step(0, 0, 0, 0, 1, 1, "R10");
    chk("R10", 32'(sq_fault), 32'd1);
    step(0, 0, 0, 0, 1, 0, "R10");
    chk("R10", 32'(sq_fault), 32'd0);
    // R11: translation disabled, no fault
    step(1, mk(6'd0, 6'd0, 0, 0, 0, 1), 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 1, "R11");
    chk("R11", 32'(sq_fault), 32'd0);
    // R10: sq bit clear allows user access
    step(1, mk(6'd0, 6'd0, 1, 0, 1, 0), 0, 0, 0, 0, "R12");
    step(0, 0, 0, 0, 1, 1, "R10");
    chk("R10", 32'(sq_fault), 32'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [31:0] wd;
      we = ($urandom % 16) == 0;
      wd = mk(6'($urandom), 6'($urandom % 4 == 0 ? 0 : $urandom), 1'($urandom),
              1'($urandom % 4 == 0), 1'($urandom), 1'($urandom));
      wd[31:22] = 10'($urandom); wd[7:4] = 4'($urandom);
      step(we, wd, ($urandom % 4) != 0, ($urandom % 5) == 0,
           1'($urandom), 1'($urandom), "R3");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule